// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is a synchronous single-port memory with a four-beat burst address generator and a flow-through read path. Address, data, chip selects, address strobes and write controls are all registered on the rising clock edge. Each edge is classified as one of four cycle kinds: deselect, begin burst, continue burst or suspend burst. There are two address strobes. The processor-side strobe always opens a read. The controller-side strobe opens a read or a write, depending on the write controls. An advance input steps the burst through a four-word group, in either interleaved or linear order. Read data appears in the same cycle as the edge that selects it, with no output stage. An asynchronous output enable can force the bus to high impedance at any time.

A sleep input powers the block down after a fixed number of sampled cycles. Stored contents are kept while asleep. While asleep, and for a short recovery window after wake-up, address strobes are refused and reported on a protocol-error flag. The array depth is a parameter, so simulation can use a small memory while keeping the full 32-bit data path.

Top module: `sram_burst_ctl`

## Requirements
- R1: The edge is a deselect, with no access and `bus_hiz` high afterwards, in three cases: `adsc_n` is low while `ce1_n` is high; a strobe is active while `ce2` is low; or a strobe is active while `ce3_n` is high. `cyc_code` reports the kind of the last edge: 0 for deselect or no access, 1 for begin, 2 for continue, 3 for suspend.
- R2: While `ce1_n` is high, a low `adsp_n` is ignored, and any burst in progress goes on as if both strobes were high.
- R3: A begin opened by `adsp_n` with `ce1_n` low is always a read, whatever the write controls say. This includes the case where `adsc_n` is low at the same edge. Memory is not changed.
- R4: A begin opened by `adsc_n` alone, with write controls asserted, writes the external address at that edge.
- R5: Lane `i` covers data bits `8*i+7:8*i`. When `gw_n` is low, all four lanes are written. Otherwise, when `bwe_n` is low, lane `i` is written where `bw_n[i]` is low. When no lane is selected, the cycle is a read. Lanes that are not written keep their contents.
- R6: When both strobes are high, `adv_n` is low and a burst is active, the burst continues. Only address bits [1:0] change, and they become start XOR count when `seq_interleave` is 1, or (start + count) mod 4 when it is 0. The count starts at 0 and wraps after 3.
- R7: When both strobes are high, `adv_n` is high and a burst is active, the burst is suspended at the current address, for both reads and writes.
- R8: Read data for the address selected by an edge is on `rdata`, with `rd_valid` high, in the cycle that follows that edge. `oe_n` high forces `bus_hiz` high and `rd_valid` low at once, without waiting for a clock edge.
- R9: A read in the cycle after a write to the same address returns the newly written data.
- R10: `pdown` rises after `sleep` has been sampled high at 2 consecutive edges, and it clears at the first edge where `sleep` is sampled low. While powered down the bus is high impedance and the burst ends. Memory contents are kept.
- R11: Strobes are ignored at any edge where `sleep` is high, where `pdown` is set, or in the 2 edges that follow the wake-up edge. Each such refused strobe sets `proto_err` for the following cycle.
- R12: Reset ends any burst and clears the sleep counters. After reset `bus_hiz` is high, `rd_valid`, `pdown` and `proto_err` are low, and `cyc_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| wdata | input | 32 | Write data |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce3_n | input | 1 | Tertiary chip enable, active low |
| gw_n | input | 1 | Write all lanes, active low |
| bwe_n | input | 1 | Per-lane write qualifier, active low |
| bw_n | input | 4 | Lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request |
| seq_interleave | input | 1 | 1 selects interleaved burst order, 0 selects linear |
| rdata | output | 32 | Flow-through read data, zero when not driven |
| rd_valid | output | 1 | Read data is being driven |
| bus_hiz | output | 1 | Data bus is high impedance |
| cyc_code | output | 2 | Kind of the last edge |
| pdown | output | 1 | Powered-down state |
| proto_err | output | 1 | Strobe refused at the previous edge |

## Verification
The properties assume that every synchronous input is known and stable at the sampling edge. They also assume that `seq_interleave` changes only between bursts, since a change mid-burst would alter the order the continue check relies on. The stimulus changes inputs only at mid-cycle, after the edge has settled. It switches burst order only when no burst is open. It releases reset with all strobes inactive, so no property sees a half-initialised decode.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    CYC_DESEL = 2'd0,
    CYC_BEGIN = 2'd1,
    CYC_CONT  = 2'd2,
    CYC_SUSP  = 2'd3
  } cyc_e;

  // Low two address bits for burst beat `step` starting at `base`.
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] step,
                                           input logic       interleave);
    return interleave ? (base ^ step) : (base + step);
  endfunction

  // Lanes to write: global write beats the per-lane qualifier.
  function automatic logic [LANES-1:0] lane_enables(input logic             gw_n,
                                                    input logic             bwe_n,
                                                    input logic [LANES-1:0] bw_n);
    if (!gw_n)       return '1;
    else if (!bwe_n) return ~bw_n;
    else             return '0;
  endfunction

endpackage

// File: rtl/sram_cyc_decode.sv
module sram_cyc_decode
  import sram_burst_pkg::*;
(
  input  logic adsp_n,
  input  logic adsc_n,
  input  logic adv_n,
  input  logic ce1_n,
  input  logic ce2,
  input  logic ce3_n,
  input  logic lane_req,
  input  logic burst_on,
  input  logic quiet,
  output cyc_e act,
  output logic wr,
  output logic strobe_seen
);

  logic adsp_live;
  logic any_live;

  assign adsp_live   = !adsp_n && !ce1_n;
  assign any_live    = adsp_live || !adsc_n;
  assign strobe_seen = !adsp_n || !adsc_n;

  always_comb begin
    act = CYC_DESEL;
    wr  = 1'b0;
    if (quiet) begin
      act = CYC_DESEL;
    end else if (!adsc_n && ce1_n) begin
      act = CYC_DESEL;
    end else if (any_live) begin
      if (!ce2 || ce3_n) begin
        act = CYC_DESEL;
      end else begin
        act = CYC_BEGIN;
        wr  = adsp_live ? 1'b0 : lane_req;
      end
    end else if (burst_on) begin
      act = adv_n ? CYC_SUSP : CYC_CONT;
      wr  = lane_req;
    end
  end

endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_e              act,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              interleave,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic              burst_on
);

  logic [1:0] base_q;
  logic [1:0] cnt_q;
  logic [1:0] cnt_inc;

  assign cnt_inc = cnt_q + 2'd1;

  always_comb begin
    case (act)
      CYC_BEGIN: nxt_addr = ext_addr;
      CYC_CONT:  nxt_addr = {addr_q[ADDR_W-1:2], burst_low(base_q, cnt_inc, interleave)};
      default:   nxt_addr = addr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      base_q   <= '0;
      cnt_q    <= '0;
      burst_on <= 1'b0;
    end else begin
      addr_q <= nxt_addr;
      case (act)
        CYC_BEGIN: begin
          base_q   <= ext_addr[1:0];
          cnt_q    <= '0;
          burst_on <= 1'b1;
        end
        CYC_CONT:  cnt_q    <= cnt_inc;
        CYC_DESEL: burst_on <= 1'b0;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/sram_sleep_ctl.sv
module sram_sleep_ctl #(
  parameter int ENTRY_CYC = 2,
  parameter int RECOV_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic pdown,
  output logic quiet
);

  localparam int EW = $clog2(ENTRY_CYC + 1);
  localparam int RW = $clog2(RECOV_CYC + 1);

  logic [EW-1:0] ent_q;
  logic [RW-1:0] rec_q;

  assign quiet = sleep || pdown || (rec_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
      rec_q <= '0;
      pdown <= 1'b0;
    end else if (sleep) begin
      rec_q <= '0;
      if (!pdown) begin
        if (ent_q == EW'(ENTRY_CYC - 1)) begin
          pdown <= 1'b1;
          ent_q <= '0;
        end else begin
          ent_q <= ent_q + 1'b1;
        end
      end
    end else begin
      ent_q <= '0;
      if (pdown) begin
        pdown <= 1'b0;
        rec_q <= RW'(RECOV_CYC);
      end else if (rec_q != '0) begin
        rec_q <= rec_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we_mask,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we_mask[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
  end

endmodule

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ENTRY_CYC = 2,
  parameter int RECOV_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [3:0]        bw_n,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic              seq_interleave,
  output logic [31:0]       rdata,
  output logic              rd_valid,
  output logic              bus_hiz,
  output logic [1:0]        cyc_code,
  output logic              pdown,
  output logic              proto_err
);

  cyc_e              act;
  logic              wr_evt;
  logic              strobe_seen;
  logic              quiet;
  logic              burst_on;
  logic [ADDR_W-1:0] burst_addr;
  logic [ADDR_W-1:0] nxt_addr;
  logic [LANES-1:0]  lane_en;
  logic [LANES-1:0]  we_mask;
  logic [DATA_W-1:0] arr_rd;
  logic              rd_q;
  logic              err_q;
  cyc_e              cyc_q;

  // Named events for the checker.
  logic begin_evt, cont_evt, susp_evt, desel_evt;
  assign begin_evt = (act == CYC_BEGIN);
  assign cont_evt  = (act == CYC_CONT);
  assign susp_evt  = (act == CYC_SUSP);
  assign desel_evt = (act == CYC_DESEL);

  assign lane_en = lane_enables(gw_n, bwe_n, bw_n);
  assign we_mask = wr_evt ? lane_en : '0;

  sram_sleep_ctl #(.ENTRY_CYC(ENTRY_CYC), .RECOV_CYC(RECOV_CYC)) u_sleep (
    .clk   (clk),
    .rst_n (rst_n),
    .sleep (sleep),
    .pdown (pdown),
    .quiet (quiet)
  );

  sram_cyc_decode u_dec (
    .adsp_n      (adsp_n),
    .adsc_n      (adsc_n),
    .adv_n       (adv_n),
    .ce1_n       (ce1_n),
    .ce2         (ce2),
    .ce3_n       (ce3_n),
    .lane_req    (|lane_en),
    .burst_on    (burst_on),
    .quiet       (quiet),
    .act         (act),
    .wr          (wr_evt),
    .strobe_seen (strobe_seen)
  );

  sram_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (act),
    .ext_addr   (addr),
    .interleave (seq_interleave),
    .addr_q     (burst_addr),
    .nxt_addr   (nxt_addr),
    .burst_on   (burst_on)
  );

  sram_lane_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk     (clk),
    .we_mask (we_mask),
    .waddr   (nxt_addr),
    .wdata   (wdata),
    .raddr   (burst_addr),
    .rdata   (arr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      err_q <= 1'b0;
      cyc_q <= CYC_DESEL;
    end else begin
      rd_q  <= !desel_evt && !wr_evt;
      err_q <= quiet && strobe_seen;
      cyc_q <= act;
    end
  end

  assign rd_valid  = rd_q && !oe_n;
  assign bus_hiz   = !rd_valid;
  assign rdata     = rd_valid ? arr_rd : '0;
  assign cyc_code  = cyc_q;
  assign proto_err = err_q;

endmodule

// File: rtl/sram_burst_chk.sv
module sram_burst_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adsp_n,
  input logic              adsc_n,
  input logic              ce1_n,
  input logic              oe_n,
  input logic              bus_hiz,
  input logic              proto_err,
  input logic              quiet,
  input logic              begin_evt,
  input logic              cont_evt,
  input logic              susp_evt,
  input logic              desel_evt,
  input logic              wr_evt,
  input logic              strobe_seen,
  input logic [ADDR_W-1:0] burst_addr
);

  AST_CE1_CTRL_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsc_n && ce1_n) |-> desel_evt); // R1

  AST_PROC_STROBE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n && adsc_n) |-> !begin_evt); // R2

  AST_PROC_BEGIN_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !ce1_n && begin_evt) |-> !wr_evt); // R3

  AST_CONTINUE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    cont_evt |=> !$stable(burst_addr)); // R6

  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    susp_evt |=> $stable(burst_addr)); // R7

  AST_OE_FORCES_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> bus_hiz); // R8

  AST_QUIET_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> (!begin_evt && !wr_evt)); // R11

  AST_QUIET_FLAGS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && strobe_seen) |=> proto_err); // R11

endmodule

bind sram_burst_ctl sram_burst_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .adsp_n      (adsp_n),
  .adsc_n      (adsc_n),
  .ce1_n       (ce1_n),
  .oe_n        (oe_n),
  .bus_hiz     (bus_hiz),
  .proto_err   (proto_err),
  .quiet       (quiet),
  .begin_evt   (begin_evt),
  .cont_evt    (cont_evt),
  .susp_evt    (susp_evt),
  .desel_evt   (desel_evt),
  .wr_evt      (wr_evt),
  .strobe_seen (strobe_seen),
  .burst_addr  (burst_addr)
);

// File: tb/sram_burst_ctl_bench.sv
module sram_burst_ctl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic        ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic        gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]  bw_n = 4'hF;
  logic        oe_n = 1'b0, sleep = 1'b0, seq_interleave = 1'b1;
  logic [31:0] rdata;
  logic        rd_valid, bus_hiz, pdown, proto_err;
  logic [1:0]  cyc_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sram_burst_ctl u_sram_burst_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .oe_n(oe_n), .sleep(sleep), .seq_interleave(seq_interleave),
    .rdata(rdata), .rd_valid(rd_valid), .bus_hiz(bus_hiz),
    .cyc_code(cyc_code), .pdown(pdown), .proto_err(proto_err)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic        sp_n, sc_n, av_n, c1_n, c2, c3_n, g_n, be_n;
    logic [3:0]  b_n;
    logic [7:0]  ad;
    logic [31:0] wd;
    logic        ev;
    logic [31:0] ed;
    logic [1:0]  ec;
  } vec_t;

  // rq  spn scn avn c1n c2 c3n gwn ben bwn ad wd  ev ed  ec
  localparam vec_t VEC [19] = '{
    '{4'd4, 1,0,1,0,1,0,0,1,4'hF,8'h10,32'hA0A0A010,0,32'h0,2'd1},          // R4 controller write begins
    '{4'd6, 1,1,0,0,1,0,0,1,4'hF,8'h00,32'hA0A0A011,0,32'h0,2'd2},          // R6 write continue -> 0x11
    '{4'd6, 1,1,0,0,1,0,0,1,4'hF,8'h00,32'hA0A0A012,0,32'h0,2'd2},          // R6 -> 0x12
    '{4'd6, 1,1,0,0,1,0,0,1,4'hF,8'h00,32'hA0A0A013,0,32'h0,2'd2},          // R6 -> 0x13
    '{4'd8, 0,1,1,0,1,0,1,1,4'hF,8'h11,32'h0,1,32'hA0A0A011,2'd1},          // R8 flow-through read
    '{4'd6, 1,1,0,0,1,0,1,1,4'hF,8'h00,32'h0,1,32'hA0A0A010,2'd2},          // R6 interleave 01^01
    '{4'd6, 1,1,0,0,1,0,1,1,4'hF,8'h00,32'h0,1,32'hA0A0A013,2'd2},          // R6 01^10
    '{4'd7, 1,1,1,0,1,0,1,1,4'hF,8'h00,32'h0,1,32'hA0A0A013,2'd3},          // R7 suspend read
    '{4'd6, 1,1,0,0,1,0,1,1,4'hF,8'h00,32'h0,1,32'hA0A0A012,2'd2},          // R6 01^11
    '{4'd3, 0,1,1,0,1,0,0,1,4'hF,8'h12,32'hDEADBEEF,1,32'hA0A0A012,2'd1},   // R3 processor begin reads
    '{4'd5, 1,1,1,0,1,0,1,0,4'hE,8'h00,32'h11223344,0,32'h0,2'd3},          // R5 lane 0 write, R7
    '{4'd9, 1,1,1,0,1,0,1,1,4'hF,8'h00,32'h0,1,32'hA0A0A044,2'd3},          // R9 R5 read back
    '{4'd1, 1,0,1,1,1,0,1,1,4'hF,8'h12,32'h0,0,32'h0,2'd0},                 // R1 ce1 high + ctrl strobe
    '{4'd1, 1,1,0,0,1,0,1,1,4'hF,8'h00,32'h0,0,32'h0,2'd0},                 // R1 no burst, no access
    '{4'd1, 1,0,1,0,0,0,1,1,4'hF,8'h12,32'h0,0,32'h0,2'd0},                 // R1 ce2 low
    '{4'd1, 0,1,1,0,1,1,1,1,4'hF,8'h12,32'h0,0,32'h0,2'd0},                 // R1 ce3 high
    '{4'd4, 1,0,1,0,1,0,1,1,4'hF,8'h12,32'h0,1,32'hA0A0A044,2'd1},          // R4 ctrl strobe read begin
    '{4'd2, 0,1,1,1,1,0,1,1,4'hF,8'h33,32'h0,1,32'hA0A0A044,2'd3},          // R2 masked strobe, suspend
    '{4'd5, 1,1,1,0,1,0,1,0,4'hF,8'h00,32'h55555555,1,32'hA0A0A044,2'd3}    // R5 no lane selected = read
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic quiet_inputs();
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hF; wdata = '0;
  endtask

  task automatic ctrl_read(input logic [7:0] a);
    quiet_inputs();
    adsc_n = 1'b0; addr = a;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) tick();
    // R12 reset state
    chk("R12 bus_hiz", 32'(bus_hiz), 32'd1);
    chk("R12 rd_valid", 32'(rd_valid), 32'd0);
    chk("R12 pdown", 32'(pdown), 32'd0);
    chk("R12 proto_err", 32'(proto_err), 32'd0);
    chk("R12 cyc_code", 32'(cyc_code), 32'd0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < 19; i++) begin
      adsp_n = VEC[i].sp_n; adsc_n = VEC[i].sc_n; adv_n = VEC[i].av_n;
      ce1_n = VEC[i].c1_n; ce2 = VEC[i].c2; ce3_n = VEC[i].c3_n;
      gw_n = VEC[i].g_n; bwe_n = VEC[i].be_n; bw_n = VEC[i].b_n;
      addr = VEC[i].ad; wdata = VEC[i].wd;
      tick();
      chk($sformatf("R%0d vec%0d valid", VEC[i].rq, i), 32'(rd_valid), 32'(VEC[i].ev));
      if (VEC[i].ev) chk($sformatf("R%0d vec%0d data", VEC[i].rq, i), rdata, VEC[i].ed);
      chk($sformatf("R%0d vec%0d cyc", VEC[i].rq, i), 32'(cyc_code), 32'(VEC[i].ec));
    end

    // R8 asynchronous output enable
    ctrl_read(8'h10); tick();
    quiet_inputs();
    chk("R8 read before oe", rdata, 32'hA0A0A010);
    oe_n = 1'b1; #1;
    chk("R8 oe high hiz", 32'(bus_hiz), 32'd1);
    chk("R8 oe high no valid", 32'(rd_valid), 32'd0);
    oe_n = 1'b0; #1;
    chk("R8 oe low data", rdata, 32'hA0A0A010);

    // R6 linear order from 0x11: 11,12,13,10
    seq_interleave = 1'b0;
    ctrl_read(8'h11); tick();
    chk("R6 linear beat0", rdata, 32'hA0A0A011);
    quiet_inputs(); adv_n = 1'b0;
    tick(); chk("R6 linear beat1", rdata, 32'hA0A0A044);
    tick(); chk("R6 linear beat2", rdata, 32'hA0A0A013);
    tick(); chk("R6 linear beat3 wrap", rdata, 32'hA0A0A010);
    quiet_inputs(); tick();
    seq_interleave = 1'b1;

    // R9 write then immediate read of same address
    quiet_inputs(); adsc_n = 1'b0; addr = 8'h20; gw_n = 1'b0; wdata = 32'hCAFE0020;
    tick();
    quiet_inputs(); adsp_n = 1'b0; addr = 8'h20;
    tick();
    chk("R9 read after write", rdata, 32'hCAFE0020);

    // R10 sleep entry
    quiet_inputs(); sleep = 1'b1;
    tick(); chk("R10 pdown after one edge", 32'(pdown), 32'd0);
    tick(); chk("R10 pdown after two edges", 32'(pdown), 32'd1);
    chk("R10 hiz while asleep", 32'(bus_hiz), 32'd1);
    // R11 strobe while asleep
    ctrl_read(8'h10); tick();
    chk("R11 err while asleep", 32'(proto_err), 32'd1);
    chk("R11 no access while asleep", 32'(rd_valid), 32'd0);
    quiet_inputs(); tick();
    chk("R11 err clears", 32'(proto_err), 32'd0);
    // wake-up edge
    sleep = 1'b0; tick();
    chk("R10 pdown clears", 32'(pdown), 32'd0);
    ctrl_read(8'h10); tick();
    chk("R11 err in recovery", 32'(proto_err), 32'd1);
    chk("R11 recovery no access", 32'(rd_valid), 32'd0);
    quiet_inputs(); tick();
    ctrl_read(8'h10); tick();
    chk("R11 no err after recovery", 32'(proto_err), 32'd0);
    chk("R10 data retained", rdata, 32'hA0A0A010);

    // R12 reset mid-burst
    quiet_inputs();
    rst_n = 1'b0; #1;
    chk("R12 async reset hiz", 32'(bus_hiz), 32'd1);
    tick(); rst_n = 1'b1;
    adv_n = 1'b0; tick();
    chk("R12 burst cleared cyc", 32'(cyc_code), 32'd0);
    chk("R12 burst cleared hiz", 32'(bus_hiz), 32'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule